// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits in the transmit path of a single-wire bus transceiver, between the controller's transmit data line and the enable of the bus low-side driver. A low transmit level asks for a dominant (pulled-low) bus, and a high level leaves the driver off so the bus floats recessive. The guard passes that request on as a registered driver command. It also watches how long the request stays dominant. A request held low past a configurable number of clock cycles is treated as a stuck transmitter: the driver is released and a timeout status flag is raised.

The driver is re-enabled only after the transmit line has been seen recessive for a minimum run of cycles. The same rule applies on every entry into normal mode, so a line that is already low when the mode changes never reaches the bus. An undervoltage flag, an overtemperature flag, or leaving normal mode forces the driver off at once. Any hysteresis on the two fault flags is handled outside this block.

A build parameter can remove the timeout, so that a static dominant level can be held for as long as needed. There is no streaming data here: every pin is a plain level signal with no handshake.

Top module: `txdom_guard`

## Requirements
- R1: While armed, in normal mode and free of faults, `drv_on` is 1 exactly when the synchronized `txd_in` is 0, and 0 when it is 1. `drv_on` follows `txd_in` three clock edges after the input changes.
- R2: With `TO_EN`=1, `drv_on` stays high for at most `TO_CYC` consecutive cycles. On the next edge the driver is released, `to_flag` rises, and both stay that way while `txd_in` remains low.
- R3: After a timeout, the guard re-arms only after `RA_CYC` consecutive synchronized high cycles of `txd_in`. A shorter high pulse leaves `drv_on` at 0 and `to_flag` at 1. `to_flag` clears on the edge that re-arms the guard.
- R4: After each entry into normal mode (`normal_mode` going 0 to 1), `drv_on` stays 0 until `RA_CYC` consecutive synchronized high cycles of `txd_in` have been seen in normal mode. A low `txd_in` at mode entry is never driven.
- R5: `uv_flag`=1 forces `drv_on` to 0 on the next edge. Once the flag clears, the driver resumes without re-arming.
- R6: `ot_flag`=1 forces `drv_on` to 0 on the next edge. Once the flag clears, the driver resumes without re-arming.
- R7: `normal_mode`=0 forces `drv_on` to 0 on the next edge and disarms the guard.
- R8: With `TO_EN`=0, a held low `txd_in` keeps `drv_on` at 1 indefinitely, and `to_flag` never rises.
- R9: While `rst_n` is low, `drv_on` and `to_flag` are 0 and the guard is disarmed. The synchronizer resets to the recessive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_in | input | 1 | Controller transmit level, asynchronous (0 = dominant request) |
| normal_mode | input | 1 | 1 while the transceiver is in normal (communicating) mode |
| uv_flag | input | 1 | Supply undervoltage indication, synchronous |
| ot_flag | input | 1 | Overtemperature indication, synchronous |
| drv_on | output | 1 | Low-side driver enable (1 = pull bus dominant) |
| to_flag | output | 1 | Dominant timeout status, held until re-arm |

## Verification
The results have different latencies:
- `drv_on` answers a change on `txd_in` after three edges: two synchronizer flops and the output register.
- `drv_on` answers the fault flags and `normal_mode` after one edge.
- `to_flag` rises on the same edge that drops the driver, one edge after the `TO_CYC`-th driven cycle.

The bench drives inputs on falling edges, lets a stated number of rising edges pass, and samples on the next falling edge. Each hold length is chosen so the sample lands at a known point. For example, a 22-edge low hold sees the last driven cycle, and one more edge sees the trip. Re-arm pulses are placed so that a pulse of `RA_CYC`-1 synchronized cycles fails to re-arm and a pulse of exactly `RA_CYC` cycles succeeds.

// File: rtl/txdom_pkg.sv
package txdom_pkg;

  typedef enum logic [1:0] {
    TG_OFF  = 2'd0,
    TG_WAIT = 2'd1,
    TG_LIVE = 2'd2,
    TG_TRIP = 2'd3
  } tg_state_e;

  function automatic int unsigned cnt_w(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

endpackage

// File: rtl/txdom_sync.sv
module txdom_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[0] <= IDLE;
        else        sr_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[i] <= IDLE;
        else        sr_q[i] <= sr_q[i-1];
      end
    end
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/txdom_runcnt.sv
module txdom_runcnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic reached
);
  localparam int unsigned   CW   = txdom_pkg::cnt_w(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // Length of the current run of 'run' cycles, saturating at LIMIT-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run)           cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  // High during the LIMIT-th (or a later) consecutive cycle of the run.
  assign reached = run && (cnt_q == LAST);
endmodule

// File: rtl/txdom_ctrl.sv
module txdom_ctrl
  import txdom_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic txd_s,
  input  logic normal_mode,
  input  logic uv_flag,
  input  logic ot_flag,
  input  logic lo_reached,
  input  logic hi_reached,
  output logic lo_run,
  output logic hi_run,
  output logic drv_on,
  output logic to_flag
);
  tg_state_e st_q, st_d;
  logic      trip, rearm, drv_d, flag_d;

  // Low runs are only timed while the driver may actually drive.
  assign lo_run = (st_q == TG_LIVE) && !txd_s;
  assign hi_run = normal_mode && txd_s;

  assign trip  = normal_mode && (st_q == TG_LIVE) && lo_reached;
  assign rearm = normal_mode && (st_q != TG_LIVE) && hi_reached;

  always_comb begin
    st_d = st_q;
    if (!normal_mode) begin
      st_d = TG_OFF;
    end else begin
      unique case (st_q)
        TG_OFF:  st_d = rearm ? TG_LIVE : TG_WAIT;
        TG_WAIT: st_d = rearm ? TG_LIVE : TG_WAIT;
        TG_TRIP: st_d = rearm ? TG_LIVE : TG_TRIP;
        TG_LIVE: st_d = trip  ? TG_TRIP : TG_LIVE;
        default: st_d = TG_OFF;
      endcase
    end
  end

  always_comb begin
    flag_d = to_flag;
    if (trip)       flag_d = 1'b1;
    else if (rearm) flag_d = 1'b0;
  end

  assign drv_d = normal_mode && !uv_flag && !ot_flag && !txd_s &&
                 (st_q == TG_LIVE) && !trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TG_OFF;
      drv_on  <= 1'b0;
      to_flag <= 1'b0;
    end else begin
      st_q    <= st_d;
      drv_on  <= drv_d;
      to_flag <= flag_d;
    end
  end
endmodule

// File: rtl/txdom_guard.sv
module txdom_guard #(
  parameter int unsigned TO_CYC      = 1200000,
  parameter int unsigned RA_CYC      = 220,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          TO_EN       = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic normal_mode,
  input  logic uv_flag,
  input  logic ot_flag,
  output logic drv_on,
  output logic to_flag
);
  // The low counter must see TO_CYC driven cycles before the trip cycle.
  localparam int unsigned LO_LIMIT = TO_CYC + 1;

  logic txd_s, lo_run, hi_run, lo_reached, hi_reached;

  txdom_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(txd_in), .q(txd_s)
  );

  txdom_runcnt #(.LIMIT(RA_CYC)) u_hi_cnt (
    .clk(clk), .rst_n(rst_n), .run(hi_run), .reached(hi_reached)
  );

  if (TO_EN) begin : g_timeout
    txdom_runcnt #(.LIMIT(LO_LIMIT)) u_lo_cnt (
      .clk(clk), .rst_n(rst_n), .run(lo_run), .reached(lo_reached)
    );
  end else begin : g_no_timeout
    assign lo_reached = 1'b0 & lo_run;
  end

  txdom_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .txd_s(txd_s), .normal_mode(normal_mode),
    .uv_flag(uv_flag), .ot_flag(ot_flag), .lo_reached(lo_reached),
    .hi_reached(hi_reached), .lo_run(lo_run), .hi_run(hi_run),
    .drv_on(drv_on), .to_flag(to_flag)
  );
endmodule

// File: rtl/txdom_guard_chk.sv
module txdom_guard_chk #(
  parameter int unsigned TO_CYC = 8,
  parameter bit          TO_EN  = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic normal_mode,
  input logic uv_flag,
  input logic ot_flag,
  input logic drv_on,
  input logic to_flag
);
  localparam int unsigned   RW  = $clog2(TO_CYC + 1);
  localparam logic [RW-1:0] TOP = RW'(TO_CYC);

  logic [RW-1:0] on_run_q;

  // Consecutive driven cycles seen before the current one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             on_run_q <= '0;
    else if (!drv_on)       on_run_q <= '0;
    else if (on_run_q != TOP) on_run_q <= on_run_q + 1'b1;
  end

  p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (TO_EN && drv_on) |-> (on_run_q < TOP));
  p_flag_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag |-> !drv_on);
  p_entry_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(normal_mode) |=> !drv_on);
  p_uv_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> !drv_on);
  p_ot_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |=> !drv_on);
  p_mode_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_mode |=> !drv_on);
  p_no_flag_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !TO_EN |-> !to_flag);
endmodule

bind txdom_guard txdom_guard_chk #(.TO_CYC(TO_CYC), .TO_EN(TO_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .normal_mode(normal_mode), .uv_flag(uv_flag),
  .ot_flag(ot_flag), .drv_on(drv_on), .to_flag(to_flag)
);

// File: tb/txdom_guard_bench.sv
module txdom_guard_bench;
  localparam int unsigned TO = 20;
  localparam int unsigned RA = 5;
  localparam int NV = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, nm = 1'b0, uv = 1'b0, ot = 1'b0;
  logic drv, flg, drv_f, flg_f;
  int   n_chk = 0, n_bad = 0, cyc = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  txdom_guard #(.TO_CYC(TO), .RA_CYC(RA), .TO_EN(1'b1)) u_txdom_guard (
    .clk(clk), .rst_n(rst_n), .txd_in(txd), .normal_mode(nm),
    .uv_flag(uv), .ot_flag(ot), .drv_on(drv), .to_flag(flg)
  );

  txdom_guard #(.TO_CYC(TO), .RA_CYC(RA), .TO_EN(1'b0)) u_txdom_guard_free (
    .clk(clk), .rst_n(rst_n), .txd_in(txd), .normal_mode(nm),
    .uv_flag(uv), .ot_flag(ot), .drv_on(drv_f), .to_flag(flg_f)
  );

  // {normal, uv, ot, txd, hold edges, expected drv, expected flag, requirement}
  function automatic logic [17:0] mkv(bit n, bit u, bit o, bit t, int h,
                                      bit ed, bit ef, int r);
    return {n, u, o, t, 8'(h), ed, ef, 4'(r)};
  endfunction

  localparam logic [17:0] VEC [NV] = '{
    mkv(1,0,0,0,10,0,0,4),  // R4 low at mode entry is not driven
    mkv(1,0,0,1,10,0,0,4),  // R4 high run arms, recessive
    mkv(1,0,0,0, 6,1,0,1),  // R1 dominant passes through
    mkv(1,0,0,1, 4,0,0,1),  // R1 recessive passes through
    mkv(1,0,0,0,22,1,0,2),  // R2 last allowed driven cycle
    mkv(1,0,0,0, 1,0,1,2),  // R2 trip edge
    mkv(1,0,0,0,50,0,1,2),  // R2 held off while low
    mkv(1,0,0,1, 4,0,1,3),  // R3 short high pulse
    mkv(1,0,0,0, 8,0,1,3),  // R3 still tripped
    mkv(1,0,0,1, 5,0,1,3),  // R3 exact-length pulse starts
    mkv(1,0,0,0, 6,1,0,3),  // R3 re-armed and driving
    mkv(1,0,0,1, 6,0,0,1),  // R1
    mkv(1,0,1,0, 6,0,0,6),  // R6 overtemperature blocks
    mkv(1,0,0,0, 4,1,0,6),  // R6 resumes after clear
    mkv(1,0,0,1, 6,0,0,1),  // R1
    mkv(1,1,0,0, 6,0,0,5),  // R5 undervoltage blocks
    mkv(1,0,0,0, 4,1,0,5),  // R5 resumes after clear
    mkv(1,0,0,1, 6,0,0,1),  // R1
    mkv(0,0,0,0, 6,0,0,7),  // R7 leaving normal mode
    mkv(1,0,0,0,10,0,0,4),  // R4 re-entry with low line
    mkv(1,0,0,1, 5,0,0,4),  // R4 re-arm pulse starts
    mkv(1,0,0,0, 4,1,0,4),  // R4 armed after pulse
    mkv(1,0,0,1, 6,0,0,1),  // R1
    mkv(0,0,0,1, 3,0,0,7),  // R7
    mkv(1,0,0,1, 2,0,0,4),  // R4 high before entry is not counted
    mkv(1,0,0,0, 6,0,0,4)   // R4 four high cycles too few
  };

  task automatic check(int rq, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %b expected %b (t=%0t)", rq, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic hold(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    hold(3);
    check(9, "reset drv", drv, 1'b0);   // R9
    check(9, "reset flag", flg, 1'b0);  // R9
    rst_n = 1'b1;
    hold(1);

    for (int i = 0; i < NV; i++) begin
      {nm, uv, ot, txd} = VEC[i][17:14];
      hold(int'(VEC[i][13:6]));
      check(int'(VEC[i][3:0]), $sformatf("vec %0d drv", i), drv, VEC[i][5]);
      check(int'(VEC[i][3:0]), $sformatf("vec %0d flag", i), flg, VEC[i][4]);
    end

    // R8: with the timeout removed, a static dominant level is held
    nm = 1'b1; txd = 1'b1; hold(8);
    txd = 1'b0; hold(60);
    check(8, "free drv held", drv_f, 1'b1);
    check(8, "free flag", flg_f, 1'b0);
    check(2, "guarded drv tripped", drv, 1'b0);
    check(2, "guarded flag", flg, 1'b1);
    txd = 1'b1; hold(4);
    check(8, "free recessive", drv_f, 1'b0);

    // R9: reset in mid-transmission clears everything
    txd = 1'b0; hold(4);
    check(1, "free drives before reset", drv_f, 1'b1);
    rst_n = 1'b0; hold(1);
    check(9, "reset drv mid-run", drv_f, 1'b0);
    check(9, "reset flag mid-run", flg, 1'b0);
    rst_n = 1'b1; hold(6);
    check(9, "disarmed after reset", drv_f, 1'b0);

    done = 1'b1;
    report();
  end
endmodule